// File: doc/BRIEF.md
# Fault report and slope-select strap latch

This block owns the logic behind one shared bidirectional pin. After supply power-on the pin acts as a strap input. While the output driver is held off, the block waits for the regulator-stable indication to stay high for a set number of clocks. It then samples the pin once and latches a slope-select bit for the bus transmitter's analog edge shaper. The bit is held until the next supply power-on, which is the active-low reset `rst_ni`. Later power-down, wake or regulator dropouts do not sample the pin again.

When the sample has been taken, the pin becomes an output that reports health, high meaning good. The block compares the transmit data with the received bus level, which is brought into the clock domain through two flops. A transmit-low/receive-high mismatch means the bus is shorted to the battery. A transmit-high/receive-low mismatch means the bus is shorted to ground. Either one pulls the pin low. A thermal-override flag forces the pin low whatever the data levels are.

Each transmit edge causes a short mismatch that lasts for the bus propagation delay. A run-length mask filters these out. If over-temperature is seen while transmit is low, the transmitter is shut down until the thermal flag clears.

Top module: `fault_slope_ctrl`

## Requirements
- R1: While `rst_ni` is low: `pin_oe_o`=0, `slope_fast_o`=0 (normal slope), `tx_shutdown_o`=0 and `pin_o`=1.
- R2: The strap is sampled on the clock edge at which `reg_stable_i` has been high for SETTLE_CYCLES consecutive edges. `pin_oe_o` rises on that same edge. If `reg_stable_i` drops low earlier, the count restarts from zero.
- R3: Slope encoding: a sampled `pin_i`=1 gives `slope_fast_o`=0 (normal 2 V/µs shaping). A sampled `pin_i`=0 gives `slope_fast_o`=1 (alternate 4 V/µs shaping).
- R4: After the sample, changes on `pin_i` and `reg_stable_i` do not change `slope_fast_o` or `pin_oe_o`. Only a reset clears them.
- R5: `pin_oe_o` stays 0 for the whole sampling window, and `slope_fast_o` keeps its reset value until the sample is taken.
- R6: When `tx_i` equals the synchronized `rx_i` and `thermal_i`=0, `pin_o`=1 (bus recessive or dominant, no fault).
- R7: When `tx_i`=0 with `rx_i`=1, or `tx_i`=1 with `rx_i`=0, for longer than the mask length, `pin_o`=0.
- R8: `thermal_i`=1 drives `pin_o` to 0 on the next edge, whatever `tx_i` and `rx_i` are.
- R9: A mismatch that lasts P cycles after synchronization reaches `pin_o` only if P > MASK_CYCLES. Shorter mismatches leave `pin_o` at 1.
- R10: `rx_i` passes through two flops. A change of `rx_i` that creates a mismatch lowers `pin_o` on the (3+MASK_CYCLES)-th edge after the change. A change that ends the mismatch raises `pin_o` on the 3rd edge after the change.
- R11: `tx_shutdown_o` is set on the edge where `thermal_i`=1 and `tx_i`=0. It stays set while `thermal_i`=1, even if `tx_i` rises, and clears on the edge after `thermal_i` falls. `thermal_i` with `tx_i`=1 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset; marks a supply power-on |
| reg_stable_i | input | 1 | Regulator output is stable |
| pin_i | input | 1 | Value read from the shared pin |
| tx_i | input | 1 | Transmit data, synchronous to clk_i |
| rx_i | input | 1 | Received bus level, asynchronous |
| thermal_i | input | 1 | Thermal override flag |
| pin_o | output | 1 | Fault output value, 1 = healthy |
| pin_oe_o | output | 1 | Pin output driver enable |
| slope_fast_o | output | 1 | Latched slope select, 1 = alternate fast slope |
| tx_shutdown_o | output | 1 | Transmitter shutdown |

## Verification
The bench attacks the strap window from three sides. It drops the regulator-stable indication partway through, and it checks that the sample lands on exactly the settling edge. A design that counts cumulative rather than consecutive cycles would sample too early. Once the strap is latched, it toggles the pin and the stable indication to catch a latch that samples again. It sweeps every combination of transmit, receive and thermal levels. It then sweeps mismatch pulse widths across the mask threshold, where an off-by-one in the mask shows up as a pulse that leaks through or a real fault that is hidden. Exact latency checks on the receive path expose a missing or extra synchronizer stage. Releasing transmit during an over-temperature event exposes a shutdown that does not hold.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic {
    SLOPE_NORMAL = 1'b0,
    SLOPE_FAST   = 1'b1
  } slope_e;

  function automatic slope_e strap_to_slope(input logic strap);
    return strap ? SLOPE_NORMAL : SLOPE_FAST;
  endfunction
endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/fsc_strap_latch.sv
module fsc_strap_latch
  import fsc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_stable_i,
  input  logic pin_i,
  output logic done_o,
  output logic slope_fast_o
);
  localparam int unsigned CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  slope_e        slope_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      slope_q <= SLOPE_NORMAL;
    end else if (!done_q) begin
      if (!reg_stable_i) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        done_q  <= 1'b1;
        slope_q <= strap_to_slope(pin_i);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o       = done_q;
  assign slope_fast_o = (slope_q == SLOPE_FAST);
endmodule

// File: rtl/fsc_fault_gen.sv
module fsc_fault_gen #(
  parameter int unsigned MASK_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_i,
  input  logic rx_sync_i,
  input  logic thermal_i,
  output logic healthy_o,
  output logic tx_shutdown_o
);
  logic mismatch;
  logic qualified;
  logic healthy_q;
  logic shut_q;

  assign mismatch = tx_i ^ rx_sync_i;

  // Mask: mismatch must persist MASK_CYCLES prior cycles before it counts
  generate
    if (MASK_CYCLES == 0) begin : g_nomask
      assign qualified = mismatch;
    end else begin : g_mask
      localparam int unsigned MW = $clog2(MASK_CYCLES + 1);
      localparam logic [MW-1:0] LIM = MW'(MASK_CYCLES);
      logic [MW-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            run_q <= '0;
        else if (!mismatch)     run_q <= '0;
        else if (run_q != LIM)  run_q <= run_q + 1'b1;
      end

      assign qualified = mismatch && (run_q == LIM);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      healthy_q <= 1'b1;
      shut_q    <= 1'b0;
    end else begin
      healthy_q <= !(thermal_i || qualified);
      shut_q    <= thermal_i && (shut_q || !tx_i);
    end
  end

  assign healthy_o     = healthy_q;
  assign tx_shutdown_o = shut_q;
endmodule

// File: rtl/fault_slope_ctrl.sv
module fault_slope_ctrl #(
  parameter int unsigned SETTLE_CYCLES = 64,
  parameter int unsigned MASK_CYCLES   = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reg_stable_i,
  input  logic pin_i,
  input  logic tx_i,
  input  logic rx_i,
  input  logic thermal_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic slope_fast_o,
  output logic tx_shutdown_o
);
  logic rx_sync;

  fsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  fsc_strap_latch #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_strap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_stable_i(reg_stable_i),
    .pin_i       (pin_i),
    .done_o      (pin_oe_o),
    .slope_fast_o(slope_fast_o)
  );

  fsc_fault_gen #(.MASK_CYCLES(MASK_CYCLES)) u_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_i         (tx_i),
    .rx_sync_i    (rx_sync),
    .thermal_i    (thermal_i),
    .healthy_o    (pin_o),
    .tx_shutdown_o(tx_shutdown_o)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic reg_stable_i,
  input logic tx_i,
  input logic thermal_i,
  input logic pin_o,
  input logic pin_oe_o,
  input logic slope_fast_o,
  input logic tx_shutdown_o
);
  // R4
  oe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |=> pin_oe_o);

  // R4
  slope_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |=> $stable(slope_fast_o));

  // R5
  slope_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !slope_fast_o);

  // R2
  sample_when_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o) |-> $past(reg_stable_i));

  // R8
  thermal_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_i |=> !pin_o);

  // R11
  shut_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thermal_i && !tx_i) |=> tx_shutdown_o);

  // R11
  shut_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thermal_i |=> !tx_shutdown_o);
endmodule

bind fault_slope_ctrl fsc_checker u_fsc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_stable_i (reg_stable_i),
  .tx_i         (tx_i),
  .thermal_i    (thermal_i),
  .pin_o        (pin_o),
  .pin_oe_o     (pin_oe_o),
  .slope_fast_o (slope_fast_o),
  .tx_shutdown_o(tx_shutdown_o)
);

// File: tb/fault_slope_ctrl_test.sv
module fault_slope_ctrl_test;
  localparam int SETTLE = 4;
  localparam int MASK   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_stable = 1'b0, pin_in = 1'b1, tx = 1'b1, rx = 1'b1, thermal = 1'b0;
  logic pin_out, pin_oe, slope_fast, tx_shut;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fault_slope_ctrl #(.SETTLE_CYCLES(SETTLE), .MASK_CYCLES(MASK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_stable_i(reg_stable), .pin_i(pin_in),
    .tx_i(tx), .rx_i(rx), .thermal_i(thermal),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .slope_fast_o(slope_fast),
    .tx_shutdown_o(tx_shut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic power_on(input logic strap);
    rst_n = 1'b0; reg_stable = 1'b0; pin_in = strap;
    tx = 1'b1; rx = 1'b1; thermal = 1'b0;
    step(2);
    chk("R1 oe", pin_oe, 1'b0);
    chk("R1 slope", slope_fast, 1'b0);
    chk("R1 shutdown", tx_shut, 1'b0);
    chk("R1 pin_o", pin_out, 1'b1);
    rst_n = 1'b1;
    step(3);
    chk("R5 oe before stable", pin_oe, 1'b0);
    reg_stable = 1'b1;
    step(2);
    chk("R5 oe mid window", pin_oe, 1'b0);
    reg_stable = 1'b0;
    step(1);
    reg_stable = 1'b1;
    step(SETTLE - 1);
    chk("R2 restart after drop", pin_oe, 1'b0);
    chk("R5 slope default in window", slope_fast, 1'b0);
    step(1);
    chk("R2 oe at settle edge", pin_oe, 1'b1);
    chk("R3 slope encoding", slope_fast, ~strap);
    pin_in = ~strap; reg_stable = 1'b0;
    step(5);
    reg_stable = 1'b1;
    step(SETTLE * 3);
    chk("R4 slope held", slope_fast, ~strap);
    chk("R4 oe held", pin_oe, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    power_on(1'b0);
    power_on(1'b1);

    // full level sweep
    for (int v = 0; v < 8; v++) begin
      logic th, t, r;
      th = v[2]; t = v[1]; r = v[0];
      thermal = 1'b0; tx = 1'b1; rx = 1'b1;
      step(10);
      thermal = th; tx = t; rx = r;
      step(10);
      if (th) chk("R8 thermal override", pin_out, 1'b0);
      else if (t == r) chk("R6 agree healthy", pin_out, 1'b1);
      else chk("R7 mismatch fault", pin_out, 1'b0);
      chk("R11 shutdown level", tx_shut, th & ~t);
    end

    // thermal latency
    thermal = 1'b0; tx = 1'b1; rx = 1'b1;
    step(10);
    thermal = 1'b1;
    step(1);
    chk("R8 next edge", pin_out, 1'b0);
    thermal = 1'b0;
    step(10);

    // rx path latency
    rx = 1'b0;
    step(2 + MASK);
    chk("R10 not yet low", pin_out, 1'b1);
    step(1);
    chk("R10 low at 3+mask", pin_out, 1'b0);
    rx = 1'b1;
    step(2);
    chk("R10 not yet high", pin_out, 1'b0);
    step(1);
    chk("R10 high at 3", pin_out, 1'b1);

    // mask threshold sweep
    for (int p = 1; p <= 7; p++) begin
      logic saw_low;
      saw_low = 1'b0;
      step(10);
      rx = 1'b0;
      for (int k = 0; k < p; k++) begin
        step(1);
        if (!pin_out) saw_low = 1'b1;
      end
      rx = 1'b1;
      for (int k = 0; k < 12; k++) begin
        step(1);
        if (!pin_out) saw_low = 1'b1;
      end
      chk($sformatf("R9 pulse width %0d", p), saw_low, (p > MASK));
    end

    // shutdown hold and release
    tx = 1'b1; rx = 1'b1; thermal = 1'b0;
    step(5);
    thermal = 1'b1; tx = 1'b0;
    step(1);
    chk("R11 set", tx_shut, 1'b1);
    tx = 1'b1;
    step(3);
    chk("R11 hold while hot", tx_shut, 1'b1);
    thermal = 1'b0;
    step(1);
    chk("R11 clear on cool", tx_shut, 1'b0);
    thermal = 1'b1;
    step(3);
    chk("R11 no set with tx high", tx_shut, 1'b0);
    thermal = 1'b0;
    step(3);
    chk("R4 slope after activity", slope_fast, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule